// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block is a data cache that sits between a processor load/store port and a slow main memory. Each line holds one 32-bit word together with a tag and a valid flag. The line is chosen by an index field taken from the 32-bit byte address. A load that hits returns its word in the same cycle. A load that misses holds the processor with a stall signal. The block then fetches the containing aligned word from memory, writes it into the line and releases the stall.

Stores use buffered write-through. Every store writes its word into the selected line, whether the tag matched or not. It also pushes an address/data entry into a small FIFO, and that FIFO drains to memory in the background. The processor is held only when the FIFO is full. A load miss waits for the FIFO to drain before it issues its own memory read, so memory sees the accesses in program order.

The processor keeps `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady while `cpu_stall` is high. An access completes at the first rising edge at which `cpu_req` is high and `cpu_stall` is low. On the memory side, the block holds one request steady until memory answers with a one-cycle `mem_ack`.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset every line is invalid, so the first load to any address stalls and issues a memory read. With no request pending, `cpu_stall` and `mem_req` are low.
- R2: Address bits 11:2 select the line and bits 31:12 form the tag. Two addresses with the same bits 11:2 and different tags evict each other. An address with a different index does not disturb a line.
- R3: A load that hits completes in a single cycle with `cpu_stall` low and `cpu_rdata` equal to the line's word, without any memory read.
- R4: A load that misses raises `cpu_stall` and issues exactly one memory read (`mem_we`=0). When `mem_ack` arrives, the line takes `mem_rdata`, and the stall drops on the next cycle with that word on `cpu_rdata`.
- R5: A load at a byte address with nonzero bits 1:0 fetches the word at the address with bits 1:0 cleared (0x3005 fetches 0x3004). A later load of that aligned word hits.
- R6: Every store, whether the tag matched or not, writes its whole word, tag and valid flag into the line. A following load of the same word hits and returns the stored value.
- R7: Each store produces one memory write (`mem_we`=1) carrying the word-aligned address and the store data. Writes reach memory in the order the stores were accepted.
- R8: A store completes in a single cycle whenever the write buffer has a free entry, even while memory has not yet accepted earlier writes.
- R9: With `WB_DEPTH` entries queued, a further store keeps `cpu_stall` high until one entry has drained. The buffer never holds more than `WB_DEPTH` entries.
- R10: A load miss issues no memory read while any write-buffer entry is still waiting. All writes queued before the miss reach memory before the read.
- R11: Once `mem_req` is raised, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged until `mem_ack`. Each `mem_ack` completes exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data word |
| cpu_rdata | output | 32 | Load data, valid when the load completes |
| cpu_stall | output | 1 | High while the pending access cannot complete |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` on reads |
| mem_ack | input | 1 | One-cycle completion of the current memory transfer |

## Verification
Loads are tried in several patterns, and each pattern separates the cold-miss path from the hit path. A repeated address shows the fill took effect. Two addresses that share an index with different tags show that the tag is compared and that the line is replaced. An unaligned byte address shows the offset bits are masked in the fetch. Stores are issued against a memory that withholds its acknowledge, which makes the write buffer visible. Single-cycle completion, the stall on a full buffer, the order of the drained writes, and a load miss held behind queued writes are each observed directly at the memory port. A memory with added latency shows that a request stays steady until acknowledged.

// File: rtl/cache_pkg.sv
// Shared types for the direct-mapped write-through cache.
// Assumes 32-bit byte addresses and 32-bit data words.
package cache_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    // One queued memory write.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_entry_t;

    // Miss sequencer state.
    typedef enum logic {
        MS_IDLE  = 1'b0,
        MS_FETCH = 1'b1
    } miss_state_t;
endpackage

// File: rtl/cache_lines.sv
// Line storage: valid flags, tags and data words.
// The lookup port reads combinationally, and one write port updates a whole line.
// Assumes: valid flags clear on synchronous reset; tag and data arrays have no reset.
module cache_lines #(
    parameter int INDEX_W = 10,
    parameter int TAG_W   = 20,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] lk_index,
    output logic               lk_valid,
    output logic [TAG_W-1:0]   lk_tag,
    output logic [DATA_W-1:0]  lk_data,
    input  logic               up_en,
    input  logic [INDEX_W-1:0] up_index,
    input  logic [TAG_W-1:0]   up_tag,
    input  logic [DATA_W-1:0]  up_data
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Valid flags: cleared by reset, set by any line update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (up_en)
            valid_q[up_index] <= 1'b1;
    end

    // Tag and data words: written together on a line update.
    always_ff @(posedge clk) begin
        if (up_en) begin
            tag_q[up_index]  <= up_tag;
            data_q[up_index] <= up_data;
        end
    end

    // Lookup port.
    always_comb begin
        lk_valid = valid_q[lk_index];
        lk_tag   = tag_q[lk_index];
        lk_data  = data_q[lk_index];
    end
endmodule

// File: rtl/wr_queue.sv
// Write buffer: a circular FIFO of pending memory writes, of any depth from 1 up.
// Assumes the caller never pushes when full and never pops when empty.
module wr_queue
    import cache_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  wr_entry_t        push_entry,
    input  logic             pop,
    output wr_entry_t        head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    wr_entry_t        slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;

    // Advance a pointer around the ring.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (push) slot_q[wr_ptr_q] <= push_entry;
    end

    // Status and head outputs.
    always_comb begin
        head  = slot_q[rd_ptr_q];
        empty = (cnt_q == '0);
        full  = (32'(cnt_q) == DEPTH);
        count = cnt_q;
    end
endmodule

// File: rtl/miss_seq.sv
// Miss sequencer: it leaves idle on a load miss and stays in fetch until the
// fill completes. Assumes the requester holds its load while stalled.
module miss_seq
    import cache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_miss,
    input  logic fill_done,
    output logic fetching
);
    miss_state_t state_q;

    // State register with fill completion taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= MS_IDLE;
        else if (state_q == MS_FETCH && fill_done)
            state_q <= MS_IDLE;
        else if (state_q == MS_IDLE && load_miss)
            state_q <= MS_FETCH;
    end

    // Decoded state.
    always_comb fetching = (state_q == MS_FETCH);
endmodule

// File: rtl/dm_wt_cache.sv
// Direct-mapped, one-word-per-line data cache with buffered write-through.
// Loads that hit complete at once. Loads that miss stall, wait for the write
// buffer to drain, then fetch and fill. Stores update the line and queue a write.
// Assumes the processor holds its request steady while cpu_stall is high.
module dm_wt_cache
    import cache_pkg::*;
#(
    parameter int INDEX_W  = 10,
    parameter int WB_DEPTH = 4,
    localparam int TAG_W   = ADDR_W - INDEX_W - 2,
    localparam int CNT_W   = $clog2(WB_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic [INDEX_W-1:0] idx;
    logic [TAG_W-1:0]   tag;
    logic [ADDR_W-1:0]  word_addr;
    logic               lk_valid;
    logic [TAG_W-1:0]   lk_tag;
    logic [DATA_W-1:0]  lk_data;
    logic               hit, load_miss, store_go, fill_done, fetching;
    logic               up_en;
    logic [DATA_W-1:0]  up_data;
    wr_entry_t          push_entry, head;
    logic               wb_empty, wb_full, wb_pop;
    logic [CNT_W-1:0]   wb_count;

    // Address split and hit decision.
    always_comb begin
        idx       = cpu_addr[INDEX_W+1:2];
        tag       = cpu_addr[ADDR_W-1:INDEX_W+2];
        word_addr = cpu_addr & ~ADDR_W'(3);
        hit       = lk_valid && (lk_tag == tag);
        load_miss = cpu_req && !cpu_we && !hit;
        store_go  = cpu_req && cpu_we && !wb_full;
        cpu_stall = load_miss || (cpu_req && cpu_we && wb_full);
        cpu_rdata = lk_data;
    end

    // Memory port: queued writes first, then the pending fetch.
    always_comb begin
        mem_we    = !wb_empty;
        mem_req   = !wb_empty || fetching;
        mem_addr  = wb_empty ? word_addr : head.addr;
        mem_wdata = head.data;
        wb_pop    = !wb_empty && mem_ack;
        fill_done = fetching && wb_empty && mem_ack;
    end

    // Line update source: store data or fetched word.
    always_comb begin
        up_en           = store_go || fill_done;
        up_data         = store_go ? cpu_wdata : mem_rdata;
        push_entry.addr = word_addr;
        push_entry.data = cpu_wdata;
    end

    cache_lines #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .lk_index(idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .up_en(up_en), .up_index(idx), .up_tag(tag), .up_data(up_data)
    );

    wr_queue #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .push(store_go), .push_entry(push_entry), .pop(wb_pop),
        .head(head), .empty(wb_empty), .full(wb_full), .count(wb_count)
    );

    miss_seq u_miss (
        .clk(clk), .rst_n(rst_n),
        .load_miss(load_miss), .fill_done(fill_done), .fetching(fetching)
    );
endmodule

// File: rtl/dm_wt_cache_chk.sv
// Protocol and ordering checks for dm_wt_cache, bound into every instance.
module dm_wt_cache_chk #(
    parameter int WB_DEPTH = 4,
    localparam int CNT_W   = $clog2(WB_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req,
    input logic             cpu_we,
    input logic [31:0]      cpu_addr,
    input logic             cpu_stall,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack,
    input logic             wb_full,
    input logic [CNT_W-1:0] wb_count
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> mem_addr[1:0] == 2'b00); // R5
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && wb_full |-> cpu_stall); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wb_count) <= WB_DEPTH); // R9
    AST_STORE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && !wb_full |-> !cpu_stall); // R8
    AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> wb_count == '0); // R10
    AST_FILL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !mem_we && cpu_req && !cpu_we
        |=> !cpu_req || cpu_we || !$stable(cpu_addr) || !cpu_stall); // R4
endmodule

bind dm_wt_cache dm_wt_cache_chk #(.WB_DEPTH(WB_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_stall(cpu_stall), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .wb_full(wb_full), .wb_count(wb_count)
);

// File: tb/test_dm_wt_cache.sv
// Directed bench: one task per scenario, each checking its own results.
module test_dm_wt_cache;
    localparam int WB_DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0, fails = 0;
    bit done = 0;

    // Memory model state
    bit          mem_block = 0;
    int          mem_lat = 0;
    int          rd_cnt = 0;
    logic [31:0] last_rd = '0;
    int          wr_n = 0;
    int          wr_before_rd = 0;
    logic [31:0] wlog_addr [16];
    logic [31:0] wlog_data [16];

    always #5 clk = ~clk;

    dm_wt_cache #(.INDEX_W(10), .WB_DEPTH(WB_DEPTH)) i_dm_wt_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    function automatic logic [31:0] pattern(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory responder: acknowledges after mem_lat cycles unless blocked.
    initial begin : mem_model
        bit          pend;
        int          waitn;
        logic [31:0] cap_a, cap_d;
        logic        cap_w;
        pend = 0; waitn = 0; cap_a = '0; cap_d = '0; cap_w = 0;
        forever begin
            @(negedge clk); #2;
            if (mem_ack) begin
                mem_ack = 0; pend = 0;
            end else if (mem_req && rst_n) begin
                if (!pend) begin
                    pend = 1; waitn = 0;
                    cap_a = mem_addr; cap_w = mem_we; cap_d = mem_wdata;
                end
                if (!mem_block) begin
                    if (waitn < mem_lat) waitn++;
                    else begin
                        chk(mem_addr == cap_a && mem_we == cap_w && (!mem_we || mem_wdata == cap_d),
                            "R11 request held", mem_addr, cap_a);
                        mem_ack = 1;
                        if (mem_we) begin
                            if (wr_n < 16) begin
                                wlog_addr[wr_n] = mem_addr;
                                wlog_data[wr_n] = mem_wdata;
                            end
                            wr_n++;
                        end else begin
                            rd_cnt++;
                            last_rd = mem_addr;
                            wr_before_rd = wr_n;
                            mem_rdata = pattern(mem_addr);
                        end
                    end
                end
            end
        end
    end

    // One processor access; cyc counts stalled cycles.
    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        #1;
        while (cpu_stall && cyc < 1000) begin
            @(negedge clk); #1;
            cyc++;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic wait_drain();
        int n;
        n = 0;
        while (mem_req && n < 1000) begin
            @(negedge clk); n++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk(cpu_stall == 0, "R1 idle stall low", 32'(cpu_stall), 0);
        chk(mem_req == 0, "R1 idle mem_req low", 32'(mem_req), 0);
    endtask

    task automatic t_miss_then_hit();
        logic [31:0] d; int c, r0;
        r0 = rd_cnt;
        access(0, 32'h0000_E00C, 0, d, c);
        chk(c > 0, "R1 cold miss stalls", c, 1);
        chk(rd_cnt == r0 + 1, "R4 one memory read", rd_cnt, r0 + 1);
        chk(last_rd == 32'h0000_E00C, "R4 read address", last_rd, 32'h0000_E00C);
        chk(d == pattern(32'h0000_E00C), "R4 fill data", d, pattern(32'h0000_E00C));
        access(0, 32'h0000_E00C, 0, d, c);
        chk(c == 0, "R3 hit single cycle", c, 0);
        chk(d == pattern(32'h0000_E00C), "R3 hit data", d, pattern(32'h0000_E00C));
        chk(rd_cnt == r0 + 1, "R3 no read on hit", rd_cnt, r0 + 1);
    endtask

    task automatic t_unaligned();
        logic [31:0] d; int c;
        access(0, 32'h0000_3005, 0, d, c);
        chk(last_rd == 32'h0000_3004, "R5 aligned fetch", last_rd, 32'h0000_3004);
        chk(d == pattern(32'h0000_3004), "R5 word data", d, pattern(32'h0000_3004));
        access(0, 32'h0000_3004, 0, d, c);
        chk(c == 0, "R5 aligned word hits", c, 0);
    endtask

    task automatic t_conflict();
        logic [31:0] d; int c, r0;
        access(0, 32'h0000_1000, 0, d, c);
        access(0, 32'h0000_2000, 0, d, c);
        chk(c > 0, "R2 same index new tag misses", c, 1);
        r0 = rd_cnt;
        access(0, 32'h0000_1000, 0, d, c);
        chk(c > 0 && rd_cnt == r0 + 1, "R2 evicted line refetched", rd_cnt, r0 + 1);
        access(0, 32'h0000_1004, 0, d, c);
        access(0, 32'h0000_1000, 0, d, c);
        chk(c == 0, "R2 other index leaves line", c, 0);
    endtask

    task automatic t_store();
        logic [31:0] d; int c, w0, r0;
        w0 = wr_n; r0 = rd_cnt;
        mem_block = 1;
        access(1, 32'h0000_0502, 32'hAAAA_0001, d, c);
        chk(c == 0, "R8 store no stall", c, 0);
        access(0, 32'h0000_0500, 0, d, c);
        chk(c == 0 && d == 32'hAAAA_0001, "R6 store miss fills line", d, 32'hAAAA_0001);
        access(1, 32'h0000_E00C, 32'hBBBB_0002, d, c);
        access(0, 32'h0000_E00C, 0, d, c);
        chk(c == 0 && d == 32'hBBBB_0002, "R6 store hit updates line", d, 32'hBBBB_0002);
        chk(rd_cnt == r0, "R6 no memory read", rd_cnt, r0);
        mem_block = 0;
        wait_drain();
        chk(wr_n == w0 + 2, "R7 one write per store", wr_n, w0 + 2);
        chk(wlog_addr[w0] == 32'h0000_0500 && wlog_data[w0] == 32'hAAAA_0001,
            "R7 first write", wlog_addr[w0], 32'h0000_0500);
        chk(wlog_addr[w0+1] == 32'h0000_E00C && wlog_data[w0+1] == 32'hBBBB_0002,
            "R7 second write in order", wlog_addr[w0+1], 32'h0000_E00C);
    endtask

    task automatic t_full();
        logic [31:0] d; int c, w0;
        w0 = wr_n;
        mem_block = 1;
        for (int i = 0; i < WB_DEPTH; i++) begin
            access(1, 32'h0000_0100 + 32'(4 * i), 32'hC000_0000 + 32'(i), d, c);
            chk(c == 0, "R8 store accepted while buffer has room", c, 0);
        end
        fork
            access(1, 32'h0000_0200, 32'hC000_00FF, d, c);
            begin
                repeat (6) @(negedge clk);
                #1;
                chk(cpu_stall == 1, "R9 full buffer stalls store", 32'(cpu_stall), 1);
                mem_block = 0;
            end
        join
        chk(c >= 5, "R9 stall lasted until drain", c, 5);
        wait_drain();
        chk(wr_n == w0 + WB_DEPTH + 1, "R9 all stores written", wr_n, w0 + WB_DEPTH + 1);
        chk(wlog_addr[w0+WB_DEPTH] == 32'h0000_0200, "R7 late store written last",
            wlog_addr[w0+WB_DEPTH], 32'h0000_0200);
    endtask

    task automatic t_read_waits();
        logic [31:0] d; int c, r0, w0;
        r0 = rd_cnt; w0 = wr_n;
        mem_block = 1;
        access(1, 32'h0000_0700, 32'hDDDD_0003, d, c);
        fork
            access(0, 32'h0000_8000, 0, d, c);
            begin
                repeat (5) @(negedge clk);
                #1;
                chk(!(mem_req && !mem_we), "R10 no read while write queued", 32'(mem_we), 1);
                mem_block = 0;
            end
        join
        chk(rd_cnt == r0 + 1, "R10 read issued after drain", rd_cnt, r0 + 1);
        chk(wr_before_rd == w0 + 1, "R10 write reached memory first", wr_before_rd, w0 + 1);
        chk(d == pattern(32'h0000_8000), "R4 fill data after wait", d, pattern(32'h0000_8000));
    endtask

    task automatic t_latency();
        logic [31:0] d; int c;
        mem_lat = 3;
        access(0, 32'h0001_0040, 0, d, c);
        chk(d == pattern(32'h0001_0040), "R11 slow read data", d, pattern(32'h0001_0040));
        access(1, 32'h0001_0044, 32'hEEEE_0004, d, c);
        wait_drain();
        chk(wlog_addr[wr_n-1] == 32'h0001_0044 && wlog_data[wr_n-1] == 32'hEEEE_0004,
            "R11 slow write data", wlog_data[wr_n-1], 32'hEEEE_0004);
        mem_lat = 0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_miss_then_hit();
        t_unaligned();
        t_conflict();
        t_store();
        t_full();
        t_read_waits();
        t_latency();
        done = 1;
        report();
        $finish;
    end
endmodule